// File: doc/BRIEF.md
# Fixed-Priority Slave Arbiter with Transaction Lock

This block sits in front of one slave port of a crossbar interconnect. Every slave gets its own copy, so masters aimed at different slaves are served in parallel and contention only arises among masters that target this particular slave in the same cycle. Each master presents a request, a lock flag and an end-of-transaction strobe. The arbiter hands the slave to exactly one master per transaction. It drives a one-hot grant vector and a binary select for the request-path multiplexer.

Arbitration uses fixed priority, and master 0 wins every tie. A winner is chosen only at transaction boundaries, so a burst is never split between masters. If the owner ends a transaction with its lock flag high, no arbitration takes place at that boundary. The owner keeps the slave for its next transaction, and even a lower-priority owner cannot be pre-empted. The owner releases the slave by ending a transaction with lock low. The grant is still held in that cycle, and the new winner appears on the next one.

The controller has three states. ARB_IDLE means no owner and an all-zero grant. ARB_XFER means an owner is in an unlocked transaction. ARB_LOCK means the owner's previous transaction ended locked. The transitions are:
- IDLE to XFER on any request (start).
- XFER to LOCK on an owner end with lock (lock_in).
- XFER or LOCK to XFER on an owner end without lock while requests are pending (handover).
- XFER or LOCK to IDLE on an owner end without lock and no request (release).
- LOCK to LOCK on an owner end with lock (relock).
In every other case the state holds.

Top module: `slave_port_arbiter`

## Requirements
- R1: During reset and on the first cycle after it, the grant vector is all zeros and the select is 0.
- R2: With no owner and no request pending, the grant stays all zeros. After an owner ends an unlocked transaction while no request is pending, the grant is all zeros on the next cycle.
- R3: From the no-owner state, the grant goes to the lowest-index requesting master one clock after the requests are sampled.
- R4: The grant has at most one bit set. When a bit i is set, the select equals i; when no bit is set, the select is 0.
- R5: Once granted, the grant does not change until the owner asserts its end-of-transaction bit. Requests from other masters, including higher-priority ones, and end-of-transaction bits from non-owners have no effect on it.
- R6: In a cycle where the owner asserts end-of-transaction with its lock bit low, the grant is unchanged. On the next cycle the grant goes to the lowest-index master requesting in that cycle, and the owner itself may win again.
- R7: In a cycle where the owner asserts end-of-transaction with its lock bit high, no arbitration happens. The owner keeps the grant on the next cycle whatever other masters request, and this repeats for each locked transaction.
- R8: A locked owner gives up the slave only by ending a transaction with lock low. In that case re-arbitration follows as in R6.
- R9: A lock bit has no effect unless it comes from the owner together with the owner's end-of-transaction bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N_MST | Per-master request for this slave |
| lock | input | N_MST | Per-master lock flag, sampled with its end-of-transaction bit |
| eot | input | N_MST | Per-master end-of-transaction strobe |
| grant | output | N_MST | One-hot grant, all zeros when the slave is free |
| sel | output | SEL_W | Binary index of the granted master |

## Verification
Two events can meet in one cycle: the owner's end-of-transaction, which carries the lock decision, and fresh requests from higher-priority masters. The bench provokes this by raising higher-index and lower-index requests in exactly the cycle where the owner ends a transaction, first with lock high and then with lock low. A cycle-level behavioural model predicts the owner after every edge. It is judged correct when the locked case keeps the owner and the unlocked case moves the grant to the lowest requesting index one cycle later. A long pseudo-random phase then mixes these collisions with end-of-transaction and lock bits from non-owners.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,
        ARB_XFER = 2'd1,
        ARB_LOCK = 2'd2
    } arb_state_t;
endpackage

// File: rtl/prio_pick.sv
module prio_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] pick,
    output logic         any
);
    logic [N:0] seen;
    assign seen[0] = 1'b0;
    for (genvar i = 0; i < N; i++) begin : g_chain
        assign pick[i]   = req[i] & ~seen[i];
        assign seen[i+1] = seen[i] | req[i];
    end
    assign any = seen[N];
endmodule

// File: rtl/oh_encode.sv
module oh_encode #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  oh,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (oh[i]) idx = idx | IW'(i);
        end
    end
endmodule

// File: rtl/slave_port_arbiter.sv
module slave_port_arbiter #(
    parameter int N_MST = 4,
    parameter int SEL_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_MST-1:0] req,
    input  logic [N_MST-1:0] lock,
    input  logic [N_MST-1:0] eot,
    output logic [N_MST-1:0] grant,
    output logic [SEL_W-1:0] sel
);
    import arb_pkg::*;

    arb_state_t       state_q, state_d;
    logic [N_MST-1:0] owner_q, owner_d;
    logic [N_MST-1:0] winner;
    logic             any_req;
    logic             own_eot, own_lock;

    prio_pick #(.N(N_MST)) u_pick (
        .req  (req),
        .pick (winner),
        .any  (any_req)
    );

    assign own_eot  = |(owner_q & eot);
    assign own_lock = |(owner_q & lock);

    // next-state and owner selection
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (any_req) begin
                    state_d = ARB_XFER;
                    owner_d = winner;
                end
            end
            ARB_XFER, ARB_LOCK: begin
                if (own_eot) begin
                    if (own_lock) begin
                        state_d = ARB_LOCK;
                    end else if (any_req) begin
                        state_d = ARB_XFER;
                        owner_d = winner;
                    end else begin
                        state_d = ARB_IDLE;
                        owner_d = '0;
                    end
                end
            end
            default: begin
                state_d = ARB_IDLE;
                owner_d = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
        end
    end

    // outputs
    logic [SEL_W-1:0] sel_raw;
    oh_encode #(.N(N_MST), .IW(SEL_W)) u_enc (
        .oh  (owner_q),
        .idx (sel_raw)
    );

    always_comb begin
        grant = owner_q;
        sel   = sel_raw;
    end

    // R4
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R4
    sel_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> grant[sel]);

    // R5
    hold_mid_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && (grant & eot) == '0) |=> $stable(grant));

    // R7
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & eot & lock) != '0) |=> $stable(grant));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && req == '0) |=> (grant == '0));

    // R3
    idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && req != '0) |=> (grant != '0));
endmodule

// File: tb/sim_slave_port_arbiter.sv
module sim_slave_port_arbiter;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0, lock = '0, eot = '0;
    logic [N-1:0] grant;
    logic [1:0]   sel;

    int    n_chk = 0, n_bad = 0;
    int    model_owner = -1;
    string tag = "R1";
    bit    done = 1'b0;

    always #2 clk = ~clk;

    slave_port_arbiter #(.N_MST(N)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .lock(lock), .eot(eot),
        .grant(grant), .sel(sel)
    );

    function automatic int lowest(input logic [N-1:0] r);
        for (int i = 0; i < N; i++) if (r[i]) return i;
        return -1;
    endfunction

    // behavioural reference: owner index, -1 for none
    always @(posedge clk) begin
        if (!rst_n) model_owner = -1;
        else if (model_owner < 0) model_owner = lowest(req);
        else if (eot[model_owner] && !lock[model_owner]) model_owner = lowest(req);
    end

    task automatic compare();
        logic [N-1:0] exp_g;
        logic [1:0]   exp_s;
        exp_g = '0;
        exp_s = '0;
        if (model_owner >= 0) begin
            exp_g[model_owner] = 1'b1;
            exp_s = 2'(model_owner);
        end
        n_chk++;
        if (grant !== exp_g) begin
            n_bad++;
            $display("FAIL %s grant actual=%b expected=%b", tag, grant, exp_g);
        end
        n_chk++;
        if (sel !== exp_s) begin
            n_bad++;
            $display("FAIL R4 sel actual=%0d expected=%0d", sel, exp_s);
        end
    endtask

    task automatic step(input logic [N-1:0] r, input logic [N-1:0] l,
                        input logic [N-1:0] e, input string t);
        @(negedge clk);
        compare();
        tag  = t;
        req  = r;
        lock = l;
        eot  = e;
    endtask

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        // R1: reset
        repeat (3) step('0, '0, '0, "R1");
        rst_n = 1'b1;
        step('0, '0, '0, "R1");
        // R2: idle stays zero
        step('0, '0, '0, "R2");
        step('0, 4'b1111, 4'b1111, "R2");
        // R3: lowest requester wins from idle
        step(4'b1100, '0, '0, "R3");
        // R5: higher requests and foreign eot do not pre-empt
        step(4'b1111, '0, '0, "R5");
        step(4'b1111, '0, 4'b0001, "R5");
        step(4'b1111, 4'b0100, '0, "R9");
        // R6: owner 2 ends unlocked, master 0 wins next
        step(4'b1111, '0, 4'b0100, "R6");
        step(4'b1010, '0, '0, "R6");
        step(4'b1010, '0, 4'b0001, "R6");
        // R7: owner 1 ends locked while master 0 requests
        step(4'b0011, '0, '0, "R7");
        step(4'b0011, 4'b0010, 4'b0010, "R7");
        step(4'b0011, 4'b0010, 4'b0010, "R7");
        step(4'b0011, '0, '0, "R7");
        // R9: non-owner lock and eot ignored, owner lock without eot ignored
        step(4'b0001, 4'b0001, 4'b0001, "R9");
        step(4'b0001, 4'b0010, '0, "R9");
        // R8: release with lock low, master 0 takes over
        step(4'b0001, '0, 4'b0010, "R8");
        step(4'b0001, '0, '0, "R8");
        // R6 owner rewins itself
        step(4'b0001, '0, 4'b0001, "R6");
        step('0, '0, '0, "R6");
        // R2: release with nothing pending
        step('0, '0, 4'b0001, "R2");
        step('0, '0, '0, "R2");
        step('0, '0, '0, "R2");
        // mixed pseudo-random traffic with collisions
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[3:0], lfsr[7:4] | lfsr[11:8], lfsr[11:8] | lfsr[15:12], "R6");
        end
        step('0, '0, '0, "R6");
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
        end
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule